// File: doc/BRIEF.md
# Virtualizable Flags Register Unit

This unit holds the 64-bit flags register of a processor core that runs two instruction sets, a legacy one and a native one. The register carries the arithmetic condition flags and the system control flags. Every write is cleaned up before it is stored: reserved positions are forced to zero and the one fixed-one position is forced to one. The unit also produces the effective interrupt-enable signal for whichever instruction set is running.

In legacy mode, interrupt masking passes through a virtualization gate. A hypervisor controls this gate with two control bits. One bit decides whether the stored interrupt flag takes part in masking at all. The other bit decides whether a change to that flag by a legacy CLI, STI or POPF raises an intercept trap. Any legacy write that tries to flip the nested-task bit is refused, and an intercept trap is raised instead. Trap pulses are registered. The write's class code tells the unit which rules apply.

Top module: `vflags_unit`

## Requirements
- R1: After a synchronous reset, the register reads 0x0000_0000_0000_0002 and both trap outputs are low.
- R2: Bit 1 always reads 1. Bits 3, 5, 15 and 63:22 always read 0, whatever value is written. The writable bits are 0, 2, 4, 6 to 14 and 16 to 21.
- R3: A write with class 0 (native register write) stores every writable bit, the nested-task bit 14 included. It raises no trap in the following cycle.
- R4: When `mode_legacy` is 0, `int_enable` equals `stat_int_en`, whatever the flag bits hold.
- R5: When `mode_legacy` is 1, `int_enable` is `stat_int_en AND (NOT ctl_virt_if OR flags[9])`. It is combinational from the current register and inputs.
- R6: A class 1 write (CLI/STI/POPF) that changes bit 9 while `ctl_intercept_en` is 1 stores the new bit. It also drives `trap_if` high in the cycle after the write.
- R7: A class 1 write raises no `trap_if` if bit 9 keeps its value, or if `ctl_intercept_en` is 0. Bit 9 is stored in both cases.
- R8: A write of class 1, 2 or 3 whose data differs from the stored bit 14 leaves bit 14 unchanged, stores the other writable bits, and drives `trap_nt` high in the following cycle.
- R9: A write of class 2 or 3 that changes bit 9 stores it without raising `trap_if`, even when `ctl_intercept_en` is 1.
- R10: Each trap pulse lasts one cycle. Both traps are low in a cycle that follows a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_legacy | input | 1 | 1 = legacy instruction set running, 0 = native |
| stat_int_en | input | 1 | Interrupt bit of the processor status register |
| ctl_virt_if | input | 1 | Control bit: stored interrupt flag takes part in legacy masking |
| ctl_intercept_en | input | 1 | Control bit: intercept legacy interrupt-flag changes |
| wr_en | input | 1 | Write strobe |
| wr_class | input | 2 | Write class: 0 native, 1 CLI/STI/POPF, 2 nested-task op, 3 other legacy |
| wr_data | input | 64 | Write data |
| flags_q | output | 64 | Current register value |
| int_enable | output | 1 | Effective interrupt enable |
| trap_if | output | 1 | Interrupt-flag intercept pulse |
| trap_nt | output | 1 | Nested-task intercept pulse |

## Verification
The bench rewrites bit 9 with the value it already holds while interception is on. A design that traps on every write, rather than only on a change, fires `trap_if` there. It flips bit 9 through classes 2 and 3 with interception enabled, which catches a trap decode that ignores the class. It tries to flip bit 14 in both directions from legacy classes, which exposes a design that stores the bit or stays silent. It writes all ones and then only the reserved and fixed bits, which shows any slip in the mask or in the forced-one bit. It also checks the legacy interrupt gate with the virtual-interrupt bit both set and cleared, which catches an inverted or missing gate term.

// File: rtl/vflags_pkg.sv
package vflags_pkg;

    localparam int FLAGS_W   = 64;
    localparam int POS_IF    = 9;
    localparam int POS_NT    = 14;
    localparam int LIVE_BITS = 22;

    // Writable positions: 0,2,4,6..14,16..21
    localparam logic [FLAGS_W-1:0] WR_MASK  = 64'h0000_0000_003F_7FD5;
    localparam logic [FLAGS_W-1:0] ONE_BITS = 64'h0000_0000_0000_0002;
    localparam logic [FLAGS_W-1:0] RST_VAL  = ONE_BITS;

    typedef enum logic [1:0] {
        WC_NATIVE = 2'd0,
        WC_IFOP   = 2'd1,
        WC_NTOP   = 2'd2,
        WC_LEGACY = 2'd3
    } wr_class_e;

    typedef struct packed {
        logic               valid;
        wr_class_e          cls;
        logic [FLAGS_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic if_hit;
        logic nt_hit;
    } trap_t;

    function automatic logic [FLAGS_W-1:0] clean_value(input logic [FLAGS_W-1:0] d);
        return (d & WR_MASK) | ONE_BITS;
    endfunction

    function automatic logic from_legacy(input wr_class_e c);
        return c != WC_NATIVE;
    endfunction

endpackage

// File: rtl/vflags_merge.sv
module vflags_merge
    import vflags_pkg::*;
#(
    parameter int W = FLAGS_W
) (
    input  logic [W-1:0] cur,
    input  wr_req_t      req,
    output logic [W-1:0] nxt,
    output logic         if_flip,
    output logic         nt_flip
);
    logic [W-1:0] cleaned;

    always_comb begin
        cleaned = clean_value(req.data);
        if_flip = req.valid && (cleaned[POS_IF] != cur[POS_IF]);
        nt_flip = req.valid && (cleaned[POS_NT] != cur[POS_NT]);
        nxt     = cur;
        if (req.valid) begin
            nxt = cleaned;
            if (from_legacy(req.cls)) begin
                nxt[POS_NT] = cur[POS_NT];
            end
        end
    end
endmodule

// File: rtl/vflags_trap_gen.sv
module vflags_trap_gen
    import vflags_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  logic    if_flip,
    input  logic    nt_flip,
    input  logic    intercept_en,
    output trap_t   trap_q
);
    trap_t trap_d;

    always_comb begin
        trap_d.if_hit = if_flip && intercept_en && (req.cls == WC_IFOP);
        trap_d.nt_hit = nt_flip && from_legacy(req.cls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= '0;
        end else begin
            trap_q <= trap_d;
        end
    end
endmodule

// File: rtl/vflags_ie_gate.sv
module vflags_ie_gate (
    input  logic mode_legacy,
    input  logic stat_i,
    input  logic virt_if,
    input  logic stored_if,
    output logic ie
);
    logic legacy_ie;

    always_comb begin
        legacy_ie = stat_i && (!virt_if || stored_if);
        ie        = mode_legacy ? legacy_ie : stat_i;
    end
endmodule

// File: rtl/vflags_unit.sv
module vflags_unit
    import vflags_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_legacy,
    input  logic                stat_int_en,
    input  logic                ctl_virt_if,
    input  logic                ctl_intercept_en,
    input  logic                wr_en,
    input  logic [1:0]          wr_class,
    input  logic [FLAGS_W-1:0]  wr_data,
    output logic [FLAGS_W-1:0]  flags_q,
    output logic                int_enable,
    output logic                trap_if,
    output logic                trap_nt
);
    wr_req_t            req;
    logic [FLAGS_W-1:0] flags_d;
    logic               if_flip;
    logic               nt_flip;
    trap_t              traps;

    always_comb begin
        req.valid = wr_en;
        req.cls   = wr_class_e'(wr_class);
        req.data  = wr_data;
    end

    vflags_merge #(.W(FLAGS_W)) u_merge (
        .cur     (flags_q),
        .req     (req),
        .nxt     (flags_d),
        .if_flip (if_flip),
        .nt_flip (nt_flip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= RST_VAL;
        end else begin
            flags_q <= flags_d;
        end
    end

    vflags_trap_gen u_traps (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .if_flip      (if_flip),
        .nt_flip      (nt_flip),
        .intercept_en (ctl_intercept_en),
        .trap_q       (traps)
    );

    vflags_ie_gate u_gate (
        .mode_legacy (mode_legacy),
        .stat_i      (stat_int_en),
        .virt_if     (ctl_virt_if),
        .stored_if   (flags_q[POS_IF]),
        .ie          (int_enable)
    );

    assign trap_if = traps.if_hit;
    assign trap_nt = traps.nt_hit;
endmodule

// File: rtl/vflags_checker.sv
module vflags_checker
    import vflags_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mode_legacy,
    input logic               stat_int_en,
    input logic               ctl_intercept_en,
    input logic               wr_en,
    input logic [1:0]         wr_class,
    input logic [FLAGS_W-1:0] wr_data,
    input logic [FLAGS_W-1:0] flags_q,
    input logic               int_enable,
    input logic               trap_if,
    input logic               trap_nt
);
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        flags_q[1] && !flags_q[3] && !flags_q[5] && !flags_q[15]
        && (flags_q[FLAGS_W-1:LIVE_BITS] == '0)); // R2

    AST_NATIVE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class == 2'd0) |=> (!trap_if && !trap_nt)); // R3

    AST_NATIVE_IE: assert property (@(posedge clk) disable iff (rst)
        !mode_legacy |-> (int_enable == stat_int_en)); // R4

    AST_IF_INTERCEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class == 2'd1 && ctl_intercept_en && (wr_data[POS_IF] != flags_q[POS_IF]))
        |=> trap_if); // R6

    AST_NT_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class != 2'd0) |=> (flags_q[POS_NT] == $past(flags_q[POS_NT]))); // R8

    AST_NT_INTERCEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_class != 2'd0 && (wr_data[POS_NT] != flags_q[POS_NT])) |=> trap_nt); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!trap_if && !trap_nt)); // R10
endmodule

bind vflags_unit vflags_checker u_vflags_checker (
    .clk              (clk),
    .rst              (rst),
    .mode_legacy      (mode_legacy),
    .stat_int_en      (stat_int_en),
    .ctl_intercept_en (ctl_intercept_en),
    .wr_en            (wr_en),
    .wr_class         (wr_class),
    .wr_data          (wr_data),
    .flags_q          (flags_q),
    .int_enable       (int_enable),
    .trap_if          (trap_if),
    .trap_nt          (trap_nt)
);

// File: tb/test_vflags_unit.sv
module test_vflags_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode_legacy, stat_int_en, ctl_virt_if, ctl_intercept_en;
    logic        wr_en;
    logic [1:0]  wr_class;
    logic [63:0] wr_data;
    logic [63:0] flags_q;
    logic        int_enable, trap_if, trap_nt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vflags_unit i_vflags_unit (
        .clk(clk), .rst(rst), .mode_legacy(mode_legacy), .stat_int_en(stat_int_en),
        .ctl_virt_if(ctl_virt_if), .ctl_intercept_en(ctl_intercept_en),
        .wr_en(wr_en), .wr_class(wr_class), .wr_data(wr_data),
        .flags_q(flags_q), .int_enable(int_enable), .trap_if(trap_if), .trap_nt(trap_nt)
    );

    typedef struct packed {
        logic        mode;
        logic        stat;
        logic        vif;
        logic        iien;
        logic        we;
        logic [1:0]  cls;
        logic [63:0] data;
        logic [63:0] exp_flags;
        logic        exp_ie;
        logic        exp_tif;
        logic        exp_tnt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,64'hFFFF_FFFF_FFFF_FFFF,64'h3F_7FD7,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd1,64'h3F_7DD7,64'h3F_7DD7,1'b0,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd1,64'h3F_7DD7,64'h3F_7DD7,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,2'd1,64'h3F_7FD7,64'h3F_7FD7,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,2'd1,64'h3F_7DD7,64'h3F_7DD7,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd2,64'h0,64'h4002,1'b0,1'b0,1'b1},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd3,64'h4200,64'h4202,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd2,64'h4000,64'h4002,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,2'd1,64'hFFFF,64'h4002,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,64'h0,64'h2,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd3,64'h4000,64'h2,1'b0,1'b0,1'b1},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd1,64'h200,64'h202,1'b1,1'b1,1'b0},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,2'd1,64'h0,64'h202,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,64'hFFFF_FFFF_FFC0_8028,64'h2,1'b1,1'b0,1'b0}
    };

    localparam string TAGS [NV] = '{
        "R2 R3 R4", "R5 R6", "R7 same-value", "R7 intercept-off", "R5 R7 gate-open",
        "R8 class2", "R9 class3", "R9 class2", "R10 R4 idle", "R3 native-nt",
        "R8 set-attempt", "R6 rising", "R10 R5 idle", "R2 reserved-only"
    };

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; mode_legacy = 1'b0; stat_int_en = 1'b0; ctl_virt_if = 1'b0;
        ctl_intercept_en = 1'b0; wr_en = 1'b0; wr_class = 2'd0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check64("R1 flags", flags_q, 64'h2);
        check1("R1 trap_if", trap_if, 1'b0);
        check1("R1 trap_nt", trap_nt, 1'b0);

        for (int i = 0; i < NV; i++) begin
            mode_legacy      = VECS[i].mode;
            stat_int_en      = VECS[i].stat;
            ctl_virt_if      = VECS[i].vif;
            ctl_intercept_en = VECS[i].iien;
            wr_en            = VECS[i].we;
            wr_class         = VECS[i].cls;
            wr_data          = VECS[i].data;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            check64({TAGS[i], " flags"}, flags_q, VECS[i].exp_flags);
            check1({TAGS[i], " int_enable"}, int_enable, VECS[i].exp_ie);
            check1({TAGS[i], " trap_if"}, trap_if, VECS[i].exp_tif);
            check1({TAGS[i], " trap_nt"}, trap_nt, VECS[i].exp_tnt);
        end

        // R4: native ignores flag bits with stored IF clear and gate set
        mode_legacy = 1'b0; stat_int_en = 1'b1; ctl_virt_if = 1'b1;
        wr_en = 1'b1; wr_class = 2'd0; wr_data = 64'h0;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check1("R4 native ie with IF=0", int_enable, 1'b1);

        // R10: trap pulse then quiet cycle
        mode_legacy = 1'b1; ctl_intercept_en = 1'b1;
        wr_en = 1'b1; wr_class = 2'd1; wr_data = 64'h200;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check1("R6 pulse", trap_if, 1'b1);
        @(posedge clk); @(negedge clk);
        check1("R10 pulse ends", trap_if, 1'b0);

        // R1: reset with a pending trap-causing write
        wr_en = 1'b1; wr_class = 2'd3; wr_data = 64'h4000; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
        check64("R1 mid-run flags", flags_q, 64'h2);
        check1("R1 mid-run trap_nt", trap_nt, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule